// File: doc/BRIEF.md
# Processor mode and stack-select controller

This block keeps the execution context of a small microcontroller core. It tracks whether the core runs ordinary code (thread mode) or an exception handler (handler mode), whether the current code is privileged, and which of two banked stack pointers is in use. The two pointers are a main pointer and a process pointer.

A two-bit control word sets the thread-mode choices. Bit 0 selects the stack and bit 1 drops the privilege. Handler mode overrides both bits: it always runs privileged and always uses the main stack.

An exception-entry strobe carries an exception number into handler mode. An exception-return strobe goes back to thread mode, and the control word then decides privilege and stack again. Only one level of exception is tracked.

The core writes stack pointers through a single port. Each write goes to whichever bank is selected at that moment.

Top module: `mode_ctrl`

## Requirements
- R1: After reset, the block is in thread mode (`handler_mode`=0) and privileged, with the main stack selected and `active_exc`=0. `msp` holds `sp_reset_val` with its low two bits cleared, and `psp` is 0.
- R2: Control bit 0 chooses the thread-mode stack: 0 selects the main pointer and 1 selects the process pointer (`use_psp`=1).
- R3: Control bit 1 sets the thread-mode privilege: 0 means privileged and 1 means unprivileged (`privileged`=0).
- R4: A control write made in thread mode while unprivileged is ignored. Unprivileged thread code can never regain privilege through the control port.
- R5: An entry strobe in thread mode switches to handler mode on the next cycle. From then on, `active_exc` shows the exception number that was sampled with the strobe.
- R6: In handler mode the block is always privileged and `use_psp` is 0, whatever the control bits hold.
- R7: An entry strobe received while already in handler mode is ignored. The mode and `active_exc` stay unchanged.
- R8: A return strobe in handler mode goes back to thread mode on the next cycle, with `active_exc`=0. Privilege and stack then follow the stored control bits again.
- R9: A stack-pointer write updates only the bank that is selected in that cycle, with bits 1:0 forced to 0. The other bank keeps its value, and `sp_active` shows the selected bank.
- R10: A return strobe received in thread mode is ignored.
- R11: A control write made in handler mode is accepted. It takes effect on privilege and stack only after the return to thread mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_reset_val | input | SPW | Main stack pointer value loaded at reset |
| exc_enter | input | 1 | Exception entry strobe |
| exc_num | input | EXCW | Exception number sampled on entry |
| exc_return | input | 1 | Exception return strobe |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 2 | Control word: bit 0 stack select, bit 1 unprivileged |
| sp_we | input | 1 | Stack pointer write enable |
| sp_wdata | input | SPW | Stack pointer write data |
| handler_mode | output | 1 | 1 in handler mode, 0 in thread mode |
| privileged | output | 1 | Effective privilege |
| use_psp | output | 1 | 1 when the process stack pointer is selected |
| active_exc | output | EXCW | Active exception number, 0 in thread mode |
| sp_active | output | SPW | Value of the selected stack pointer |
| msp | output | SPW | Main stack pointer bank |
| psp | output | SPW | Process stack pointer bank |

## Verification
Each state register updates at the first rising edge after a strobe or write is presented. Mode, privilege, stack select, exception number and both pointer banks are therefore due exactly one cycle after the stimulus. Inputs are driven on the falling edge and held for one cycle, and every output is sampled on the following falling edge, after that single register stage. Ignored strobes and writes are checked the same way: the outputs are expected to hold their previous values at that sample point.

// File: rtl/mode_ctrl.sv
module mode_ctrl #(
  parameter int SPW  = 32,
  parameter int EXCW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SPW-1:0]  sp_reset_val,
  input  logic            exc_enter,
  input  logic [EXCW-1:0] exc_num,
  input  logic            exc_return,
  input  logic            ctl_we,
  input  logic [1:0]      ctl_wdata,
  input  logic            sp_we,
  input  logic [SPW-1:0]  sp_wdata,
  output logic            handler_mode,
  output logic            privileged,
  output logic            use_psp,
  output logic [EXCW-1:0] active_exc,
  output logic [SPW-1:0]  sp_active,
  output logic [SPW-1:0]  msp,
  output logic [SPW-1:0]  psp
);
  localparam int ALIGN = 2;
  localparam logic [SPW-1:0] ALIGN_MASK = ~SPW'((1 << ALIGN) - 1);

  logic [1:0]      ctl_q;
  logic            hnd_q;
  logic [EXCW-1:0] exc_q;
  logic [SPW-1:0]  msp_q, psp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= 2'b00;
      hnd_q <= 1'b0;
      exc_q <= '0;
      msp_q <= sp_reset_val & ALIGN_MASK;
      psp_q <= '0;
    end else begin
      if (ctl_we && privileged) ctl_q <= ctl_wdata;
      if (!hnd_q && exc_enter) begin
        hnd_q <= 1'b1;
        exc_q <= exc_num;
      end else if (hnd_q && exc_return) begin
        hnd_q <= 1'b0;
        exc_q <= '0;
      end
      if (sp_we) begin
        if (use_psp) psp_q <= sp_wdata & ALIGN_MASK;
        else         msp_q <= sp_wdata & ALIGN_MASK;
      end
    end
  end

  assign handler_mode = hnd_q;
  assign privileged   = hnd_q | ~ctl_q[1];
  assign use_psp      = ~hnd_q & ctl_q[0];
  assign active_exc   = hnd_q ? exc_q : '0;
  assign sp_active    = use_psp ? psp_q : msp_q;
  assign msp          = msp_q;
  assign psp          = psp_q;
endmodule

module mode_ctrl_chk #(
  parameter int SPW  = 32,
  parameter int EXCW = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_enter,
  input logic [EXCW-1:0] exc_num,
  input logic            exc_return,
  input logic            sp_we,
  input logic            handler_mode,
  input logic            privileged,
  input logic            use_psp,
  input logic [EXCW-1:0] active_exc,
  input logic [SPW-1:0]  msp,
  input logic [SPW-1:0]  psp
);
  // R6
  handler_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> (privileged && !use_psp));

  // R8
  thread_exc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !handler_mode |-> (active_exc == '0));

  // R5
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter && !handler_mode) |=> (handler_mode && active_exc == $past(exc_num)));

  // R7
  no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_mode && !exc_return) |=> (handler_mode && $stable(active_exc)));

  // R4
  no_regain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!handler_mode && !privileged && !exc_enter) |=> !privileged);

  // R9
  bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && !use_psp) |=> $stable(psp));

  // R9
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msp[1:0] == 2'b00) && (psp[1:0] == 2'b00));
endmodule

bind mode_ctrl mode_ctrl_chk #(.SPW(SPW), .EXCW(EXCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_enter(exc_enter), .exc_num(exc_num),
  .exc_return(exc_return), .sp_we(sp_we), .handler_mode(handler_mode),
  .privileged(privileged), .use_psp(use_psp), .active_exc(active_exc),
  .msp(msp), .psp(psp)
);

// File: tb/tb_mode_ctrl.sv
module tb_mode_ctrl;
  localparam int SPW = 32;
  localparam int EXCW = 9;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SPW-1:0] sp_reset_val = 32'h2000_0FFF;
  logic exc_enter = 1'b0, exc_return = 1'b0, ctl_we = 1'b0, sp_we = 1'b0;
  logic [EXCW-1:0] exc_num = '0;
  logic [1:0] ctl_wdata = 2'b00;
  logic [SPW-1:0] sp_wdata = '0;
  logic handler_mode, privileged, use_psp;
  logic [EXCW-1:0] active_exc;
  logic [SPW-1:0] sp_active, msp, psp;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  mode_ctrl #(.SPW(SPW), .EXCW(EXCW)) dut (
    .clk(clk), .rst_n(rst_n), .sp_reset_val(sp_reset_val),
    .exc_enter(exc_enter), .exc_num(exc_num), .exc_return(exc_return),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .handler_mode(handler_mode), .privileged(privileged), .use_psp(use_psp),
    .active_exc(active_exc), .sp_active(sp_active), .msp(msp), .psp(psp)
  );

  // {enter, num[8:0], ret, ctl_we, ctl_wdata[1:0], exp_hnd, exp_priv, exp_psp, exp_exc[8:0]}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 9'd0,  1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 9'd0},  // R2
    {1'b1, 9'd5,  1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 9'd5},  // R5 R6
    {1'b1, 9'd9,  1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 9'd5},  // R7
    {1'b0, 9'd0,  1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 9'd0},  // R8
    {1'b0, 9'd0,  1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 9'd0},  // R10
    {1'b0, 9'd0,  1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 9'd0},  // R3
    {1'b0, 9'd0,  1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 9'd0},  // R4
    {1'b1, 9'd17, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 9'd17}, // R6
    {1'b0, 9'd0,  1'b0, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 9'd17}, // R11
    {1'b0, 9'd0,  1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 9'd0},  // R11
    {1'b0, 9'd0,  1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 9'd0}   // R8
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    {exc_enter, exc_return, ctl_we, sp_we} = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 mode", 64'(handler_mode), 64'd0);
    check("R1 priv", 64'(privileged), 64'd1);
    check("R1 psp sel", 64'(use_psp), 64'd0);
    check("R1 exc", 64'(active_exc), 64'd0);
    check("R1 msp", 64'(msp), 64'h2000_0FFC);
    check("R1 psp", 64'(psp), 64'd0);

    for (int i = 0; i < NV; i++) begin
      exc_enter = VEC[i][25];
      exc_num = VEC[i][24:16];
      exc_return = VEC[i][15];
      ctl_we = VEC[i][14];
      ctl_wdata = VEC[i][13:12];
      @(negedge clk);
      {exc_enter, exc_return, ctl_we} = '0;
      check($sformatf("vec%0d mode", i), 64'(handler_mode), 64'(VEC[i][11]));
      check($sformatf("vec%0d priv", i), 64'(privileged), 64'(VEC[i][10]));
      check($sformatf("vec%0d stack", i), 64'(use_psp), 64'(VEC[i][9]));
      check($sformatf("vec%0d exc", i), 64'(active_exc), 64'(VEC[i][8:0]));
    end

    // R9: main bank selected
    sp_we = 1'b1; sp_wdata = 32'h1234_5677;
    @(negedge clk); sp_we = 1'b0;
    check("R9 msp write", 64'(msp), 64'h1234_5674);
    check("R9 psp kept", 64'(psp), 64'd0);
    check("R9 active", 64'(sp_active), 64'h1234_5674);

    // R9: process bank selected
    ctl_we = 1'b1; ctl_wdata = 2'b01;
    idle_cycle();
    sp_we = 1'b1; sp_wdata = 32'hABCD_0003;
    @(negedge clk); sp_we = 1'b0;
    check("R9 psp write", 64'(psp), 64'hABCD_0000);
    check("R9 msp kept", 64'(msp), 64'h1234_5674);
    check("R9 active psp", 64'(sp_active), 64'hABCD_0000);

    // R6 R9: handler writes the main bank
    exc_enter = 1'b1; exc_num = 9'd3;
    idle_cycle();
    sp_we = 1'b1; sp_wdata = 32'h0000_8001;
    @(negedge clk); sp_we = 1'b0;
    check("R6 msp write in handler", 64'(msp), 64'h0000_8000);
    check("R6 psp kept", 64'(psp), 64'hABCD_0000);

    // R8: return restores process stack
    exc_return = 1'b1;
    idle_cycle();
    check("R8 stack restored", 64'(use_psp), 64'd1);
    check("R8 active", 64'(sp_active), 64'hABCD_0000);

    // R1: reset again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset psp", 64'(psp), 64'd0);
    check("R1 reset stack", 64'(use_psp), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule